// File: doc/BRIEF.md
# Sound Controller Sample Buffer Slave

This block is a byte-wide bus slave that holds a sound controller's 2 KB sample store together with a small bank of eight control registers. The lower half of a 4 KB bus window (offsets 0x000 to 0x7FF) reaches the sample store. The upper half starts at 0x800, where the eight registers sit. Everything above those eight register offsets reads as zero.

How the sample store answers depends on the operating mode held in the mode register. In the streaming (PCM) mode, the store acts as an append-only queue. The bus address only chooses a channel, and a write pointer decides where each byte goes. In stereo, the left and right channels each use one 1 KB half with a pointer of their own. In mono, one pointer walks the whole 2 KB. In the other modes (off, wavetable and the reserved code), the store is ordinary random-access memory addressed by the bus offset. The pointers advance only on bus writes in streaming mode. Nothing here plays samples or raises interrupts.

Top module: `snd_sample_buf`

## Requirements
- R1: After reset, every register reads 0x00 except the interrupt-status slot. The identification register at 0x800 always reads the constant VERSION_ID (default 0x00), and writes to it are dropped.
- R2: The mode register at 0x801 stores only bits [1:0] of a write and reads back with bits [7:2] as zero. Codes: 0 off, 1 streaming, 2 wavetable, 3 reserved.
- R3: The interrupt-status slot at 0x804 always reads 0xFF, and writes to it have no effect.
- R4: Reads at bus offsets 0x808 to 0xFFF return 0x00, and writes there change nothing.
- R5: Offsets 0x802 (channel setup, bit 1 = stereo), 0x803, 0x805, 0x806 and 0x807 store and return a full byte.
- R6: When the mode is not 1, a buffer access at offset A (A < 0x800) reads or writes store byte A.
- R7: In mode 1 with stereo clear, a buffer write stores at the left pointer's low 11 bits and then adds one to the left pointer, whatever the offset.
- R8: In mode 1 with stereo set, a buffer write with offset bit 10 clear stores at the left pointer's low 10 bits and then adds one to the left pointer.
- R9: In mode 1 with stereo set, a buffer write with offset bit 10 set stores at 0x400 plus the right pointer's low 10 bits and then adds one to the right pointer.
- R10: In mode 1, a buffer read ignores its offset. It returns the byte at 0x400 plus the right pointer's low 10 bits in stereo, or at the left pointer's low 11 bits in mono.
- R11: Pointers are at least 11 bits wide and are masked rather than clamped. After 1024 stereo left writes, the left pointer lands on the same location again. A mono read after stereo use takes 11 bits of the same left pointer.
- R12: Read data for a request sampled at one clock edge appears on bus_rdata after that same edge, and it stays until the next read.
- R13: Reads in any mode, and buffer writes outside mode 1, leave both pointers unchanged. The pointers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUF_AW+1 (12) | Byte offset in the 4 KB window |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |

## Verification
Every read result takes exactly one register stage. The bench drives each request just after a falling edge, lets one rising edge pass, and samples bus_rdata at the next falling edge. Write effects, including pointer steps and mode changes, take hold at the edge that samples the write. So the very next access already sees the new state, and the bench model is updated at the same point in its sequence. Pointer behaviour is visible only through reads. The bench therefore checks it in two ways: by streaming-mode reads, and by switching to off mode and reading the exact locations the model says were written.

// File: rtl/sndbuf_pkg.sv
package sndbuf_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_PCM  = 2'd1,
      MODE_WAVE = 2'd2,
      MODE_RSVD = 2'd3
   } snd_mode_e;

   typedef enum logic [2:0] {
      RK_CONST,
      RK_MODE,
      RK_RW,
      RK_ONES,
      RK_ZERO
   } reg_kind_e;

   localparam int REG_IDENT    = 0;
   localparam int REG_MODE     = 1;
   localparam int REG_CHAN     = 2;
   localparam int REG_IRQ_STAT = 4;
   localparam int MAPPED_REGS  = 8;
   localparam int STEREO_BIT   = 1;

   function automatic reg_kind_e kind_of(input int idx);
      if (idx >= MAPPED_REGS)      return RK_ZERO;
      else if (idx == REG_IDENT)   return RK_CONST;
      else if (idx == REG_MODE)    return RK_MODE;
      else if (idx == REG_IRQ_STAT) return RK_ONES;
      else                         return RK_RW;
   endfunction

endpackage

// File: rtl/sndbuf_regs.sv
module sndbuf_regs
   import sndbuf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int REG_AW = 3,
   parameter int MODE_W = 2,
   parameter logic [DATA_W-1:0] VERSION_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              in_win,
   input  logic [REG_AW-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_q,
   output logic [MODE_W-1:0] mode_o,
   output logic              stereo_o
);

   localparam int REG_CNT = 1 << REG_AW;

   logic [DATA_W-1:0] rd_vec [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      localparam reg_kind_e KIND = kind_of(i);
      logic hit;
      assign hit = wr_en && in_win && (idx == REG_AW'(i));

      if (KIND == RK_RW) begin : g_rw
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
         assign rd_vec[i] = q;
      end else if (KIND == RK_MODE) begin : g_mode
         logic [MODE_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata[MODE_W-1:0];
         end
         assign rd_vec[i] = DATA_W'(q);
      end else if (KIND == RK_CONST) begin : g_const
         assign rd_vec[i] = VERSION_ID;
      end else if (KIND == RK_ONES) begin : g_ones
         assign rd_vec[i] = '1;
      end else begin : g_zero
         assign rd_vec[i] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= in_win ? rd_vec[idx] : '0;
   end

   assign mode_o   = rd_vec[REG_MODE][MODE_W-1:0];
   assign stereo_o = rd_vec[REG_CHAN][STEREO_BIT];

endmodule

// File: rtl/sndbuf_ptrs.sv
module sndbuf_ptrs #(
   parameter int BUF_AW = 11,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pcm,
   input  logic              stereo,
   input  logic              wr,
   input  logic [BUF_AW-1:0] bus_off,
   output logic [BUF_AW-1:0] mem_addr,
   output logic [PTR_W-1:0]  left_ptr,
   output logic [PTR_W-1:0]  right_ptr
);

   localparam int HALF_AW = BUF_AW - 1;

   logic right_half;
   logic adv_l, adv_r;

   assign right_half = bus_off[BUF_AW-1];
   assign adv_l = wr && pcm && (!stereo || !right_half);
   assign adv_r = wr && pcm && stereo && right_half;

   always_comb begin
      if (!pcm)
         mem_addr = bus_off;
      else if (stereo)
         mem_addr = (wr && !right_half) ? {1'b0, left_ptr[HALF_AW-1:0]}
                                        : {1'b1, right_ptr[HALF_AW-1:0]};
      else
         mem_addr = left_ptr[BUF_AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_ptr  <= '0;
         right_ptr <= '0;
      end else begin
         if (adv_l) left_ptr  <= left_ptr + PTR_W'(1);
         if (adv_r) right_ptr <= right_ptr + PTR_W'(1);
      end
   end

endmodule

// File: rtl/sndbuf_ram.sv
module sndbuf_ram #(
   parameter int AW     = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      if (re) q <= mem[addr];
   end

endmodule

// File: rtl/snd_sample_buf.sv
module snd_sample_buf
   import sndbuf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BUF_AW = 11,
   parameter int REG_AW = 3,
   parameter int MODE_W = 2,
   parameter int PTR_W  = 16,
   parameter logic [DATA_W-1:0] VERSION_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [BUF_AW:0]   bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   if (REG_AW < 3 || REG_AW >= BUF_AW) begin : g_bad_reg_aw
      $error("REG_AW must cover eight registers and fit below BUF_AW");
   end
   if (PTR_W < BUF_AW) begin : g_bad_ptr_w
      $error("PTR_W must be at least BUF_AW");
   end
   if (MODE_W < 2 || MODE_W > DATA_W) begin : g_bad_mode_w
      $error("MODE_W must hold the four mode codes");
   end
   if (DATA_W <= STEREO_BIT) begin : g_bad_data_w
      $error("DATA_W too small for the channel setup field");
   end

   logic              is_buf, in_win;
   logic              buf_wr, buf_rd, reg_wr, reg_rd;
   logic [MODE_W-1:0] mode;
   logic              stereo, pcm;
   logic [BUF_AW-1:0] mem_addr;
   logic [PTR_W-1:0]  left_ptr, right_ptr;
   logic [DATA_W-1:0] ram_q, reg_q;
   logic              sel_buf_q;

   assign is_buf = !bus_addr[BUF_AW];
   assign in_win = (bus_addr[BUF_AW-1:REG_AW] == '0);
   assign buf_wr = bus_en &&  bus_we &&  is_buf;
   assign buf_rd = bus_en && !bus_we &&  is_buf;
   assign reg_wr = bus_en &&  bus_we && !is_buf;
   assign reg_rd = bus_en && !bus_we && !is_buf;
   assign pcm    = (mode == MODE_W'(MODE_PCM));

   sndbuf_regs #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .MODE_W(MODE_W), .VERSION_ID(VERSION_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .in_win(in_win),
      .idx(bus_addr[REG_AW-1:0]), .wdata(bus_wdata), .rd_q(reg_q),
      .mode_o(mode), .stereo_o(stereo)
   );

   sndbuf_ptrs #(.BUF_AW(BUF_AW), .PTR_W(PTR_W)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .pcm(pcm), .stereo(stereo), .wr(buf_wr),
      .bus_off(bus_addr[BUF_AW-1:0]), .mem_addr(mem_addr),
      .left_ptr(left_ptr), .right_ptr(right_ptr)
   );

   sndbuf_ram #(.AW(BUF_AW), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .we(buf_wr), .re(buf_rd), .addr(mem_addr),
      .wdata(bus_wdata), .q(ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 sel_buf_q <= 1'b0;
      else if (bus_en && !bus_we) sel_buf_q <= is_buf;
   end

   assign bus_rdata = sel_buf_q ? ram_q : reg_q;

endmodule

// File: rtl/sndbuf_chk.sv
module sndbuf_chk #(
   parameter int DATA_W = 8,
   parameter int BUF_AW = 11,
   parameter int REG_AW = 3,
   parameter int MODE_W = 2,
   parameter int PTR_W  = 16,
   parameter logic [DATA_W-1:0] VERSION_ID = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [BUF_AW:0]   bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [MODE_W-1:0] mode,
   input logic              stereo,
   input logic [PTR_W-1:0]  left_ptr,
   input logic [PTR_W-1:0]  right_ptr
);

   localparam logic [BUF_AW:0] BASE = (BUF_AW+1)'(1) << BUF_AW;
   localparam logic [BUF_AW:0] A_ID   = BASE;
   localparam logic [BUF_AW:0] A_MODE = BASE | (BUF_AW+1)'(1);
   localparam logic [BUF_AW:0] A_FCTL = BASE | (BUF_AW+1)'(3);
   localparam logic [BUF_AW:0] A_IRQ  = BASE | (BUF_AW+1)'(4);

   logic rd, wr, buf_acc, pcm_mode;
   assign rd       = bus_en && !bus_we;
   assign wr       = bus_en &&  bus_we;
   assign buf_acc  = !bus_addr[BUF_AW];
   assign pcm_mode = (mode == MODE_W'(1));

   // R1
   ident_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && bus_addr == A_ID |=> bus_rdata == VERSION_ID);

   // R2
   mode_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && bus_addr == A_MODE |=> mode == $past(bus_wdata[MODE_W-1:0]));

   // R3
   irq_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && bus_addr == A_IRQ |=> bus_rdata == '1);

   // R4
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !buf_acc && bus_addr[BUF_AW-1:REG_AW] != '0 |=> bus_rdata == '0);

   // R5
   rw_reg_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && bus_addr == A_FCTL ##1 rd && bus_addr == A_FCTL
      |=> bus_rdata == $past(bus_wdata, 2));

   // R6
   plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && buf_acc && !pcm_mode |=> $stable(left_ptr) && $stable(right_ptr));

   // R7
   mono_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && buf_acc && pcm_mode && !stereo
      |=> left_ptr == $past(left_ptr) + PTR_W'(1) && $stable(right_ptr));

   // R9
   right_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && buf_acc && pcm_mode && stereo && bus_addr[BUF_AW-1]
      |=> right_ptr == $past(right_ptr) + PTR_W'(1) && $stable(left_ptr));

   // R13
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> $stable(left_ptr) && $stable(right_ptr));

endmodule

bind snd_sample_buf sndbuf_chk #(
   .DATA_W(DATA_W), .BUF_AW(BUF_AW), .REG_AW(REG_AW), .MODE_W(MODE_W),
   .PTR_W(PTR_W), .VERSION_ID(VERSION_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .mode(mode), .stereo(stereo), .left_ptr(left_ptr), .right_ptr(right_ptr)
);

// File: tb/tb_snd_sample_buf.sv
`timescale 1ns/1ps
module tb_snd_sample_buf;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;

   int n_run = 0;
   int n_fail = 0;

   logic [7:0]  m_mem [2048];
   logic [7:0]  m_reg [8];
   logic [15:0] m_lp, m_rp;

   always #10 clk = ~clk;

   snd_sample_buf dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic m_pcm();
      return m_reg[1][1:0] == 2'd1;
   endfunction

   function automatic logic m_st();
      return m_reg[2][1];
   endfunction

   function automatic logic [7:0] exp_rd(input logic [11:0] a);
      if (!a[11]) begin
         if (m_pcm()) return m_st() ? m_mem[{1'b1, m_rp[9:0]}] : m_mem[m_lp[10:0]];
         return m_mem[a[10:0]];
      end
      if (a[10:3] != 0) return 8'h00;
      if (a[2:0] == 3'd0) return 8'h00;
      if (a[2:0] == 3'd4) return 8'hFF;
      return m_reg[a[2:0]];
   endfunction

   function automatic string req_of(input logic [11:0] a);
      if (!a[11]) return m_pcm() ? "R10" : "R6";
      if (a[10:3] != 0) return "R4";
      case (a[2:0])
         3'd0: return "R1";
         3'd1: return "R2";
         3'd4: return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic m_wr(input logic [11:0] a, input logic [7:0] d);
      if (!a[11]) begin
         if (m_pcm()) begin
            if (m_st()) begin
               if (!a[10]) begin m_mem[{1'b0, m_lp[9:0]}] = d; m_lp++; end
               else        begin m_mem[{1'b1, m_rp[9:0]}] = d; m_rp++; end
            end else begin
               m_mem[m_lp[10:0]] = d; m_lp++;
            end
         end else m_mem[a[10:0]] = d;
      end else if (a[10:3] == 0) begin
         case (a[2:0])
            3'd0, 3'd4: ;
            3'd1: m_reg[1] = {6'b0, d[1:0]};
            default: m_reg[a[2:0]] = d;
         endcase
      end
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      m_wr(a, d);
   endtask

   // result is due one edge after the request (R12)
   task automatic rd_chk(input logic [11:0] a, input string req);
      logic [7:0] e;
      e = exp_rd(a);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      check(req, bus_rdata, e);
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      m_lp = '0; m_rp = '0;
      for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R3: reset values of the register bank
      for (int i = 0; i < 8; i++)
         rd_chk(12'h800 + 12'(i), (i == 4) ? "R3" : "R1");

      // R6: fill the store in off mode, then read it back
      for (int a = 0; a < 2048; a++) wr(12'(a), 8'($urandom));
      for (int i = 0; i < 40; i++) rd_chk(12'($urandom % 2048), "R6");

      // R2 / R3 / R1 / R4 / R5 directed register cases
      wr(12'h801, 8'hFF); rd_chk(12'h801, "R2");
      wr(12'h804, 8'h12); rd_chk(12'h804, "R3");
      wr(12'h800, 8'h5A); rd_chk(12'h800, "R1");
      wr(12'hC3F, 8'h77); rd_chk(12'hC3F, "R4"); rd_chk(12'h808, "R4");
      wr(12'h803, 8'hA7); rd_chk(12'h803, "R5");
      wr(12'h805, 8'h3C); rd_chk(12'h805, "R5");
      wr(12'h806, 8'h81); rd_chk(12'h806, "R5");
      wr(12'h807, 8'hE4); rd_chk(12'h807, "R5");
      wr(12'h802, 8'hF5); rd_chk(12'h802, "R5");

      // R6 in reserved mode 3 and wavetable mode 2
      wr(12'h123, 8'hA5); rd_chk(12'h123, "R6");
      wr(12'h801, 8'h02);
      wr(12'h7FE, 8'h5B); rd_chk(12'h7FE, "R6");

      // R12: back-to-back reads each return their own byte one edge later
      wr(12'h005, 8'h11); wr(12'h006, 8'h22);
      rd_chk(12'h005, "R12"); rd_chk(12'h006, "R12");

      // R7: mono streaming write ignores the offset
      wr(12'h802, 8'h00); wr(12'h801, 8'h01);
      wr(12'h7FF, 8'hC1);
      rd_chk(12'h333, "R10");
      wr(12'h801, 8'h00); rd_chk(12'h000, "R7");

      // R8 / R9: stereo streaming, left and right halves
      wr(12'h802, 8'h02); wr(12'h801, 8'h01);
      wr(12'h010, 8'h3C); wr(12'h400, 8'h4D);
      rd_chk(12'h0AB, "R10");
      wr(12'h801, 8'h00);
      rd_chk(12'h001, "R8"); rd_chk(12'h400, "R9");

      // R11: 1024 left writes wrap within the left half
      wr(12'h801, 8'h01);
      for (int i = 0; i < 1024; i++) wr(12'h000, 8'(i + 1));
      wr(12'h000, 8'hEE);
      wr(12'h801, 8'h00);
      rd_chk(12'h002, "R11"); rd_chk(12'h402, "R11"); rd_chk(12'h001, "R11");
      wr(12'h802, 8'h00); wr(12'h801, 8'h01);
      rd_chk(12'h000, "R11");

      // R13: reads and non-streaming writes leave the pointers alone
      rd_chk(12'h100, "R13"); rd_chk(12'h7FF, "R13");
      wr(12'h801, 8'h02);
      wr(12'h010, 8'h99); wr(12'h403, 8'h98);
      wr(12'h801, 8'h01);
      rd_chk(12'h200, "R13");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [11:0] a;
         r = int'($urandom % 100);
         if (r < 5)       wr(12'h801, 8'($urandom));
         else if (r < 10) wr(12'h802, 8'($urandom));
         else if (r < 45) wr(12'($urandom % 2048), 8'($urandom));
         else if (r < 80) begin
            a = 12'($urandom % 2048);
            rd_chk(a, req_of(a));
         end else if (r < 92) begin
            a = (($urandom % 4) == 0) ? 12'($urandom) | 12'h800 : 12'h800 + 12'($urandom % 8);
            rd_chk(a, req_of(a));
         end else begin
            a = 12'h800 + 12'($urandom % 16);
            wr(a, 8'($urandom));
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule